// File: doc/BRIEF.md
# Cache Replacement Victim Selector

This block holds the replacement bookkeeping for every set of a set-associative cache and names the way to evict when a miss needs room. An elaboration parameter picks one of three policies. Under first-in-first-out, the oldest fill goes first. Under least-recently-used, the way touched longest ago goes first. Under least-frequently-used, the way with the fewest accesses goes first. The tag directory outside the block reports three kinds of event: a fill of a way, a hit on a way, and a flush of the whole cache. Each fill or hit carries a set index and a way number.

A lookup presents a set index on `query_set`. The victim for that set appears combinationally on `victim_way` in the same cycle, so the directory can use it for the fill it is about to issue. Tag compare and valid bits are kept outside the block. With one way per set the block reduces to a constant and holds no state.

Top module: `repl_victim_sel`

## Requirements
- R1: After reset, every set reports victim way 0. The first-in/recency order lists ways 0, 1, 2, ... from oldest to newest, and every access count is zero.
- R2: Under FIFO (`POLICY` = 0), the victim is the way whose last fill is oldest. Hits never change the victim.
- R3: Under LRU (`POLICY` = 1), the victim is the way whose last fill or hit is oldest. For example, after fills of ways 0..3 and hits on 1, 0, 3, 2, the victim is way 1.
- R4: A fill makes its way the newest in FIFO and LRU order, and sets its LFU count to one.
- R5: Under LFU (`POLICY` = 2), each hit adds one to the way's count. The victim is the way with the smallest count, and on a tie the lowest-numbered way wins.
- R6: LFU counts are `CNT_W` bits wide (4 by default) and stick at their maximum, 15 by default, instead of wrapping.
- R7: Events on one set never change the victim reported for any other set.
- R8: A flush returns every set to the reset state of R1 at the next clock edge. Fills and hits in the same cycle as a flush are dropped.
- R9: If a fill and a hit name the same set in one cycle, only the fill takes effect. If they name different sets, both take effect.
- R10: `victim_way` follows `query_set` in the same cycle. It reflects every event up to the last clock edge and none from the current cycle.
- R11: With `WAYS` = 1, `victim_way` is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_en | input | 1 | A way was refilled this cycle |
| fill_set | input | SET_W | Set of the refill |
| fill_way | input | WAY_W | Way of the refill |
| hit_en | input | 1 | A lookup hit this cycle |
| hit_set | input | SET_W | Set of the hit |
| hit_way | input | WAY_W | Way of the hit |
| flush | input | 1 | Return all replacement state to reset values |
| query_set | input | SET_W | Set whose victim is requested |
| victim_way | output | WAY_W | Way to evict in `query_set` |

## Verification
The bench builds four copies of the block with 4 sets. Three have 4 ways, one for each policy, and the fourth has a single way. All four take the same event stream, so one sequence shows how the policies differ: hits that reorder LRU, hits that FIFO ignores, and counts that LFU ties or saturates. The 4-bit counters saturate after a short run of hits. The single-way copy exercises the stateless variant. Four sets are enough for a fill and a hit in the same cycle to land on either the same set or different sets.

// File: rtl/repl_pkg.sv
package repl_pkg;

   typedef enum logic [1:0] {
      REPL_FIFO = 2'd0,
      REPL_LRU  = 2'd1,
      REPL_LFU  = 2'd2
   } repl_policy_e;

   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/repl_age_set.sv
// Age ranks of one set: 0 is newest, WAYS-1 is next to evict.
module repl_age_set #(
   parameter int WAYS  = 4,
   parameter int WAY_W = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clr,
   input  logic                        touch,
   input  logic [WAY_W-1:0]            touch_way,
   output logic [WAYS-1:0][WAY_W-1:0]  rank_o
);

   logic [WAY_W-1:0] touched_rank;
   assign touched_rank = rank_o[touch_way];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < WAYS; w++) rank_o[w] <= WAY_W'(WAYS - 1 - w);
      end else if (clr) begin
         for (int w = 0; w < WAYS; w++) rank_o[w] <= WAY_W'(WAYS - 1 - w);
      end else if (touch) begin
         for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == touch_way)
               rank_o[w] <= '0;
            else if (rank_o[w] < touched_rank)
               rank_o[w] <= rank_o[w] + 1'b1;
         end
      end
   end

endmodule

// File: rtl/repl_use_set.sv
// Saturating access counters of one set.
module repl_use_set #(
   parameter int WAYS  = 4,
   parameter int WAY_W = 2,
   parameter int CNT_W = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clr,
   input  logic                        fill,
   input  logic [WAY_W-1:0]            fill_way,
   input  logic                        hit,
   input  logic [WAY_W-1:0]            hit_way,
   output logic [WAYS-1:0][CNT_W-1:0]  cnt_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o <= '0;
      end else if (clr) begin
         cnt_o <= '0;
      end else if (fill) begin
         cnt_o[fill_way] <= CNT_W'(1);
      end else if (hit && cnt_o[hit_way] != CNT_MAX) begin
         cnt_o[hit_way] <= cnt_o[hit_way] + 1'b1;
      end
   end

endmodule

// File: rtl/repl_lfu_pick.sv
// Smallest count wins; a strict compare keeps the lowest way on ties.
module repl_lfu_pick #(
   parameter int WAYS  = 4,
   parameter int WAY_W = 2,
   parameter int CNT_W = 4
) (
   input  logic [WAYS-1:0][CNT_W-1:0] cnt_i,
   output logic [WAY_W-1:0]           way_o
);

   logic [CNT_W-1:0] best;

   always_comb begin
      way_o = '0;
      best  = cnt_i[0];
      for (int w = 1; w < WAYS; w++) begin
         if (cnt_i[w] < best) begin
            best  = cnt_i[w];
            way_o = WAY_W'(w);
         end
      end
   end

endmodule

// File: rtl/repl_victim_sel.sv
module repl_victim_sel #(
   parameter repl_pkg::repl_policy_e POLICY = repl_pkg::REPL_LRU,
   parameter int WAYS  = 4,
   parameter int SETS  = 4,
   parameter int CNT_W = 4,
   localparam int WAY_W = repl_pkg::idx_w(WAYS),
   localparam int SET_W = repl_pkg::idx_w(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fill_en,
   input  logic [SET_W-1:0] fill_set,
   input  logic [WAY_W-1:0] fill_way,
   input  logic             hit_en,
   input  logic [SET_W-1:0] hit_set,
   input  logic [WAY_W-1:0] hit_way,
   input  logic             flush,
   input  logic [SET_W-1:0] query_set,
   output logic [WAY_W-1:0] victim_way
);

   if (WAYS < 1 || WAYS > 16) begin : g_bad_ways
      $error("repl_victim_sel: WAYS must be 1..16");
   end
   if (SETS < 1) begin : g_bad_sets
      $error("repl_victim_sel: SETS must be at least 1");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("repl_victim_sel: CNT_W must be at least 1");
   end

   if (WAYS == 1) begin : g_single
      assign victim_way = '0;
   end else if (POLICY == repl_pkg::REPL_LFU) begin : g_lfu
      logic [SETS-1:0][WAYS-1:0][CNT_W-1:0] cnt;
      for (genvar s = 0; s < SETS; s++) begin : g_set
         logic fill_here, hit_here;
         assign fill_here = fill_en && (fill_set == SET_W'(s));
         assign hit_here  = hit_en && (hit_set == SET_W'(s)) && !fill_here;
         repl_use_set #(.WAYS(WAYS), .WAY_W(WAY_W), .CNT_W(CNT_W)) u_use (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (flush),
            .fill     (fill_here),
            .fill_way (fill_way),
            .hit      (hit_here),
            .hit_way  (hit_way),
            .cnt_o    (cnt[s])
         );
      end
      repl_lfu_pick #(.WAYS(WAYS), .WAY_W(WAY_W), .CNT_W(CNT_W)) u_pick (
         .cnt_i (cnt[query_set]),
         .way_o (victim_way)
      );
   end else begin : g_rank
      localparam bit HIT_REORDERS = (POLICY == repl_pkg::REPL_LRU);
      logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] rank;
      for (genvar s = 0; s < SETS; s++) begin : g_set
         logic fill_here, hit_here;
         assign fill_here = fill_en && (fill_set == SET_W'(s));
         assign hit_here  = HIT_REORDERS && hit_en && (hit_set == SET_W'(s));
         repl_age_set #(.WAYS(WAYS), .WAY_W(WAY_W)) u_age (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (flush),
            .touch     (fill_here || hit_here),
            .touch_way (fill_here ? fill_way : hit_way),
            .rank_o    (rank[s])
         );
      end
      always_comb begin
         victim_way = '0;
         for (int w = 0; w < WAYS; w++) begin
            if (rank[query_set][w] == WAY_W'(WAYS - 1)) victim_way = WAY_W'(w);
         end
      end
   end

endmodule

// File: rtl/repl_victim_sel_chk.sv
module repl_victim_sel_chk #(
   parameter repl_pkg::repl_policy_e POLICY = repl_pkg::REPL_LRU,
   parameter int WAYS  = 4,
   parameter int SETS  = 4,
   parameter int CNT_W = 4,
   localparam int WAY_W = repl_pkg::idx_w(WAYS),
   localparam int SET_W = repl_pkg::idx_w(SETS)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fill_en,
   input logic [SET_W-1:0] fill_set,
   input logic [WAY_W-1:0] fill_way,
   input logic             hit_en,
   input logic [SET_W-1:0] hit_set,
   input logic [WAY_W-1:0] hit_way,
   input logic             flush,
   input logic [SET_W-1:0] query_set,
   input logic [WAY_W-1:0] victim_way
);

   localparam bit IS_FIFO = (POLICY == repl_pkg::REPL_FIFO);
   localparam bit IS_LRU  = (POLICY == repl_pkg::REPL_LRU);
   localparam bit RANKED  = (POLICY != repl_pkg::REPL_LFU) && (WAYS > 1);

   // R2: a lone hit leaves the FIFO victim of an unchanged query in place
   a_r2_fifo_hit_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (IS_FIFO && hit_en && !fill_en && !flush)
      |=> (query_set != $past(query_set)) || (victim_way == $past(victim_way)));

   // R3: the way just hit is most recent, so it cannot be the LRU victim
   a_r3_lru_hit_not_victim: assert property (@(posedge clk) disable iff (!rst_n)
      (IS_LRU && WAYS > 1 && hit_en && !flush && !(fill_en && fill_set == hit_set))
      |=> (query_set != $past(hit_set)) || (victim_way != $past(hit_way)));

   // R4: a freshly filled way is newest under FIFO and LRU
   a_r4_fill_not_victim: assert property (@(posedge clk) disable iff (!rst_n)
      (RANKED && fill_en && !flush)
      |=> (query_set != $past(fill_set)) || (victim_way != $past(fill_way)));

   // R8: flush returns every set to way 0 as victim
   a_r8_flush_resets: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (victim_way == '0));

   // R1: the victim always names an existing way
   a_r1_victim_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      int'(victim_way) < WAYS);

endmodule

bind repl_victim_sel repl_victim_sel_chk #(
   .POLICY (POLICY),
   .WAYS   (WAYS),
   .SETS   (SETS),
   .CNT_W  (CNT_W)
) u_chk (.*);

// File: tb/repl_victim_sel_tb.sv
module repl_victim_sel_tb;
   import repl_pkg::*;

   localparam int NW = 4;
   localparam int NS = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fill_en = 1'b0, hit_en = 1'b0, flush = 1'b0;
   logic [1:0] fill_set = '0, hit_set = '0, query_set = '0;
   logic [1:0] fill_way = '0, hit_way = '0;
   logic [1:0] vic_lru, vic_fifo, vic_lfu;
   logic       vic_dm;

   always #10 clk = ~clk;   // 50 MHz

   repl_victim_sel #(.POLICY(REPL_LRU), .WAYS(NW), .SETS(NS)) u_dut (
      .clk, .rst_n, .fill_en, .fill_set, .fill_way, .hit_en, .hit_set,
      .hit_way, .flush, .query_set, .victim_way(vic_lru));
   repl_victim_sel #(.POLICY(REPL_FIFO), .WAYS(NW), .SETS(NS)) u_dut_fifo (
      .clk, .rst_n, .fill_en, .fill_set, .fill_way, .hit_en, .hit_set,
      .hit_way, .flush, .query_set, .victim_way(vic_fifo));
   repl_victim_sel #(.POLICY(REPL_LFU), .WAYS(NW), .SETS(NS)) u_dut_lfu (
      .clk, .rst_n, .fill_en, .fill_set, .fill_way, .hit_en, .hit_set,
      .hit_way, .flush, .query_set, .victim_way(vic_lfu));
   repl_victim_sel #(.POLICY(REPL_LRU), .WAYS(1), .SETS(NS)) u_dut_dm (
      .clk, .rst_n, .fill_en, .fill_set, .fill_way(fill_way[0]), .hit_en,
      .hit_set, .hit_way(hit_way[0]), .flush, .query_set, .victim_way(vic_dm));

   int checks = 0;
   int errors = 0;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Reference model: timestamps for order, plain ints for counts
   int stf[NS][NW];
   int stl[NS][NW];
   int cnt[NS][NW];
   int now = 0;

   function automatic void model_reset();
      for (int s = 0; s < NS; s++)
         for (int w = 0; w < NW; w++) begin
            stf[s][w] = w - NW;
            stl[s][w] = w - NW;
            cnt[s][w] = 0;
         end
   endfunction

   function automatic int argmin(input int v[NW]);
      int b = 0;
      for (int w = 1; w < NW; w++) if (v[w] < v[b]) b = w;
      return b;
   endfunction

   typedef struct {
      int    e_fifo;
      int    e_lru;
      int    e_lfu;
      string tag;
   } exp_t;
   exp_t sb[$];

   task automatic step(input bit fe, input int fs, input int fw,
                       input bit he, input int hs, input int hw,
                       input bit fl, input int qs, input string tag);
      int pre_lru;
      exp_t e;
      @(negedge clk);
      fill_en = fe; fill_set = 2'(fs); fill_way = 2'(fw);
      hit_en = he;  hit_set = 2'(hs);  hit_way = 2'(hw);
      flush = fl;   query_set = 2'(qs);
      pre_lru = argmin(stl[qs]);
      #1;
      chk("R10 pre-edge lru", int'(vic_lru), pre_lru);
      if (fl) model_reset();
      else begin
         if (fe) begin
            now++;
            stf[fs][fw] = now; stl[fs][fw] = now; cnt[fs][fw] = 1;
         end
         if (he && !(fe && fs == hs)) begin
            now++;
            stl[hs][hw] = now;
            if (cnt[hs][hw] < 15) cnt[hs][hw]++;
         end
      end
      e.e_fifo = argmin(stf[qs]);
      e.e_lru  = argmin(stl[qs]);
      e.e_lfu  = argmin(cnt[qs]);
      e.tag    = tag;
      sb.push_back(e);
      @(posedge clk);
      #1;
      fill_en = 1'b0; hit_en = 1'b0; flush = 1'b0;
   endtask

   task automatic fill(input int s, input int w, input string tag);
      step(1, s, w, 0, 0, 0, 0, s, tag);
   endtask
   task automatic hit(input int s, input int w, input string tag);
      step(0, 0, 0, 1, s, w, 0, s, tag);
   endtask
   task automatic look(input int s, input string tag);
      step(0, 0, 0, 0, 0, 0, 0, s, tag);
   endtask

   // Monitor: compare after each edge, away from both clock edges
   always @(posedge clk) begin
      #5;
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         chk({e.tag, " fifo"}, int'(vic_fifo), e.e_fifo);
         chk({e.tag, " lru"},  int'(vic_lru),  e.e_lru);
         chk({e.tag, " lfu"},  int'(vic_lfu),  e.e_lfu);
         chk({e.tag, " R11 single-way"}, int'(vic_dm), 0);
      end
   end

   bit done = 1'b0;
   initial begin
      #(20 * 50000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      for (int s = 0; s < NS; s++) begin
         query_set = 2'(s);
         #1;
         chk("R1 reset fifo", int'(vic_fifo), 0);
         chk("R1 reset lru", int'(vic_lru), 0);
         chk("R1 reset lfu", int'(vic_lfu), 0);
      end
      rst_n = 1'b1;

      // R4: fills walk the ways in order; R3 LRU example
      for (int w = 0; w < NW; w++) fill(0, w, "R4 fill set0");
      hit(0, 1, "R3 hit"); hit(0, 0, "R3 hit");
      hit(0, 3, "R3 hit"); hit(0, 2, "R3/R2 hits done");
      // R2: FIFO replaces oldest fills in turn
      fill(0, 0, "R2 refill 0");
      fill(0, 1, "R2 refill 1");

      // R5: LFU example on set 1, R7 set 0 untouched
      for (int w = 0; w < NW; w++) fill(1, w, "R5 fill set1");
      hit(1, 1, "R5"); hit(1, 1, "R5");
      hit(1, 0, "R5"); hit(1, 0, "R5"); hit(1, 0, "R5");
      hit(1, 3, "R5");
      for (int i = 0; i < 4; i++) hit(1, 2, "R5 counts");
      look(1, "R5 lowest count");
      look(0, "R7 other set");

      // R6: saturation on set 2
      for (int w = 0; w < NW; w++) fill(2, w, "R6 fill set2");
      for (int i = 0; i < 20; i++) hit(2, 3, "R6 hammer");
      for (int w = 0; w < 3; w++)
         for (int i = 0; i < 14; i++) hit(2, w, "R6 level");
      look(2, "R6 saturated tie");

      // R9: same-set fill beats hit, different sets both apply
      for (int w = 0; w < NW; w++) fill(3, w, "R9 fill set3");
      hit(3, 0, "R9 prep");
      step(1, 3, 2, 1, 3, 1, 0, 3, "R9 same set");
      step(1, 1, 3, 1, 3, 1, 0, 3, "R9 split sets");
      look(1, "R9 other set");

      // R8: flush resets every set and drops the same-cycle fill
      step(1, 0, 0, 1, 2, 0, 1, 0, "R8 flush");
      for (int s = 0; s < NS; s++) look(s, "R8 after flush");
      fill(2, 0, "R8 R4 fill after flush");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule